// File: doc/BRIEF.md
# Supply-Supervised Reset Generator

This block turns a digitized supply-status bit into the system reset. Reset is held from the moment the block's own reset is applied. It drops only once the supply has read good for a continuous window of `DELAY_TICKS` periods of a slow tick input, which is 200 ms nominal. A supply-bad reading forces reset again at once, and so does a single-cycle watchdog expiry pulse. Either event restarts the whole window from zero.

A bus-inhibit output follows the reset state, so serial-interface logic can abandon a transfer and refuse new ones. A small gate hands out start grants for nonvolatile writes. It grants nothing while reset is active, but a write already running keeps its busy indication until its completion strobe arrives. The `ACTIVE_LOW` parameter sets the reset pin polarity.

Top module: `supv_rst_gen`

## Requirements
- R1: While `rst` is high, `sys_reset` is active, `bus_inhibit` is 1, and `nvw_grant` and `nvw_busy` are 0.
- R2: Reset becomes inactive on the clock edge that samples the `DELAY_TICKS`-th tick after the synchronized supply has read good without a break.
- R3: `supply_ok` passes through `SYNC_STAGES` flops. A low level on it makes reset active `SYNC_STAGES`+1 clock edges later.
- R4: A supply-bad reading of even one cycle during the qualification window discards the ticks counted so far, and a full `DELAY_TICKS` window is needed again.
- R5: A one-cycle `wdt_bite` pulse makes reset active on the next edge, and release then needs a full fresh window.
- R6: With `ACTIVE_LOW`=1, `sys_reset` is 0 when active. With `ACTIVE_LOW`=0, it is 1 when active.
- R7: `bus_inhibit` is 1 exactly while reset is active.
- R8: A request on `nvw_req` while reset is inactive and no write is busy produces a one-cycle `nvw_grant` on the next edge, and `nvw_busy` rises on that edge. No grant is produced while reset is active or a write is busy.
- R9: `nvw_busy` stays 1 across reset assertion until `nvw_done` is seen, then it falls on the next edge.
- R10: Ticks arriving while the supply reads bad have no effect on the later release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick | input | 1 | One-cycle timebase strobe for the qualification window |
| supply_ok | input | 1 | Digitized supply comparator, 1 = above trip level (asynchronous) |
| wdt_bite | input | 1 | One-cycle watchdog expiry pulse |
| nvw_req | input | 1 | Request to start a nonvolatile write |
| nvw_done | input | 1 | Completion strobe of the running write |
| sys_reset | output | 1 | System reset, polarity per `ACTIVE_LOW` |
| bus_inhibit | output | 1 | 1 while serial transfers must be aborted and refused |
| nvw_grant | output | 1 | One-cycle permission to start a write |
| nvw_busy | output | 1 | A granted write has not yet completed |

## Verification
The hardest case to reach is a supply dip that falls inside the qualification window, after some ticks are already counted. If the window is not restarted, the release comes early, and only by a few ticks. The stimulus counts ticks exactly. It removes the supply for one clock after three ticks, then gives `DELAY_TICKS`-1 fresh ticks and expects reset still held, then one more tick and expects release. The write that outlives a watchdog reset is reached by getting a grant first and firing the watchdog before `nvw_done`.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    QS_HOLD  = 2'd0,
    QS_COUNT = 2'd1,
    QS_RUN   = 2'd2
  } qual_state_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/supv_qualify.sv
module supv_qualify
  import supv_pkg::*;
#(
  parameter int DELAY_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  input  logic tick,
  input  logic wdt_bite,
  output logic active
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  qual_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          abort;

  assign abort = !good || wdt_bite;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      QS_HOLD: begin
        cnt_d = '0;
        if (!abort) state_d = QS_COUNT;
      end
      QS_COUNT: begin
        if (abort) begin
          state_d = QS_HOLD;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q == LAST) begin
            state_d = QS_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      QS_RUN: begin
        cnt_d = '0;
        if (abort) state_d = QS_HOLD;
      end
      default: begin
        state_d = QS_HOLD;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= QS_HOLD;
      cnt_q   <= '0;
      active  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      active  <= (state_d != QS_RUN);
    end
  end

  // R3
  bad_forces_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !good |=> active);

  // R5
  bite_forces_reset_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_bite |=> active);

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(tick) && $past(good)));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/supv_nvw_gate.sv
module supv_nvw_gate (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic req,
  input  logic done,
  output logic grant,
  output logic busy
);
  logic allow;

  assign allow = req && !active && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      busy  <= 1'b0;
    end else begin
      grant <= allow;
      busy  <= (busy && !done) || allow;
    end
  end

  // R8
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);

  // R8
  grant_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> busy);

  // R9
  busy_survives_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(active) && $past(busy) && !$past(done)) |-> busy);
endmodule

// File: rtl/supv_rst_gen.sv
module supv_rst_gen #(
  parameter int DELAY_TICKS = 200,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic wdt_bite,
  input  logic nvw_req,
  input  logic nvw_done,
  output logic sys_reset,
  output logic bus_inhibit,
  output logic nvw_grant,
  output logic nvw_busy
);
  logic good_s;
  logic active;

  supv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (supply_ok),
    .dout(good_s)
  );

  supv_qualify #(.DELAY_TICKS(DELAY_TICKS)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .good    (good_s),
    .tick    (tick),
    .wdt_bite(wdt_bite),
    .active  (active)
  );

  supv_nvw_gate u_gate (
    .clk   (clk),
    .rst   (rst),
    .active(active),
    .req   (nvw_req),
    .done  (nvw_done),
    .grant (nvw_grant),
    .busy  (nvw_busy)
  );

  assign bus_inhibit = active;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign sys_reset = ~active;
    end else begin : g_high
      assign sys_reset = active;
    end
  endgenerate

  // R7
  inhibit_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_inhibit) |-> !nvw_grant);
endmodule

// File: tb/supv_rst_gen_test.sv
module supv_rst_gen_test;
  localparam int D = 5;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, supply_ok = 1'b0, wdt_bite = 1'b0, nvw_req = 1'b0, nvw_done = 1'b0;
  logic sr_lo, inh, grant, busy;
  logic sr_hi, inh_hi, grant_hi, busy_hi;

  always #4 clk = ~clk;

  supv_rst_gen #(.DELAY_TICKS(D), .SYNC_STAGES(S), .ACTIVE_LOW(1'b1)) uut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .wdt_bite(wdt_bite),
    .nvw_req(nvw_req), .nvw_done(nvw_done), .sys_reset(sr_lo), .bus_inhibit(inh),
    .nvw_grant(grant), .nvw_busy(busy));

  supv_rst_gen #(.DELAY_TICKS(D), .SYNC_STAGES(S), .ACTIVE_LOW(1'b0)) uut_hi (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .wdt_bite(wdt_bite),
    .nvw_req(nvw_req), .nvw_done(nvw_done), .sys_reset(sr_hi), .bus_inhibit(inh_hi),
    .nvw_grant(grant_hi), .nvw_busy(busy_hi));

  typedef struct {
    string tag;
    logic  act;
    logic  grant;
    logic  busy;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic expect_state(input string tag, input logic act, input logic g, input logic b);
    exp_t e;
    #1;
    e.tag = tag; e.act = act; e.grant = g; e.busy = b;
    q.push_back(e);
    #2;
  endtask

  task automatic cmp(input string tag, input string what, input logic got, input logic want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, got, want);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "sys_reset(low)", sr_lo, ~e.act);
        cmp(e.tag, "sys_reset(high)", sr_hi, e.act);
        cmp(e.tag, "bus_inhibit", inh, e.act);
        cmp(e.tag, "nvw_grant", grant, e.grant);
        cmp(e.tag, "nvw_busy", busy, e.busy);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    cyc(3);
    // R1, R6, R7: reset state
    expect_state("R1", 1'b1, 1'b0, 1'b0);
    supply_ok = 1'b1;
    cyc(2);
    expect_state("R1", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    // R10: ticks while synchronized supply still bad / not yet qualified
    supply_ok = 1'b0;
    give_ticks(8);
    expect_state("R10", 1'b1, 1'b0, 1'b0);
    supply_ok = 1'b1;
    cyc(S + 2);
    give_ticks(D - 1);
    expect_state("R10", 1'b1, 1'b0, 1'b0);
    give_ticks(1);
    // R2: release on the last tick
    expect_state("R2", 1'b0, 1'b0, 1'b0);
    cyc(3);
    expect_state("R2", 1'b0, 1'b0, 1'b0);

    // R3: supply drop seen SYNC_STAGES+1 edges later
    supply_ok = 1'b0;
    cyc(S);
    expect_state("R3", 1'b0, 1'b0, 1'b0);
    cyc(1);
    expect_state("R3", 1'b1, 1'b0, 1'b0);
    // R8: request ignored while reset active
    nvw_req = 1'b1;
    cyc(1);
    nvw_req = 1'b0;
    expect_state("R8", 1'b1, 1'b0, 1'b0);

    // R4: dip during the window restarts it
    supply_ok = 1'b1;
    cyc(S + 2);
    give_ticks(3);
    supply_ok = 1'b0;
    cyc(1);
    supply_ok = 1'b1;
    cyc(S + 3);
    give_ticks(D - 1);
    expect_state("R4", 1'b1, 1'b0, 1'b0);
    give_ticks(1);
    expect_state("R4", 1'b0, 1'b0, 1'b0);

    // R8: grant, then no grant while busy
    nvw_req = 1'b1;
    cyc(1);
    nvw_req = 1'b0;
    expect_state("R8", 1'b0, 1'b1, 1'b1);
    cyc(1);
    expect_state("R8", 1'b0, 1'b0, 1'b1);
    nvw_req = 1'b1;
    cyc(1);
    nvw_req = 1'b0;
    expect_state("R8", 1'b0, 1'b0, 1'b1);

    // R5 + R9: watchdog bite while a write runs
    wdt_bite = 1'b1;
    cyc(1);
    wdt_bite = 1'b0;
    expect_state("R5", 1'b1, 1'b0, 1'b1);
    cyc(2);
    expect_state("R9", 1'b1, 1'b0, 1'b1);
    nvw_done = 1'b1;
    cyc(1);
    nvw_done = 1'b0;
    expect_state("R9", 1'b1, 1'b0, 1'b0);
    give_ticks(D - 1);
    expect_state("R5", 1'b1, 1'b0, 1'b0);
    give_ticks(1);
    expect_state("R5", 1'b0, 1'b0, 1'b0);

    // R8: done and fresh grant
    nvw_req = 1'b1;
    cyc(1);
    nvw_req = 1'b0;
    expect_state("R8", 1'b0, 1'b1, 1'b1);
    nvw_done = 1'b1;
    cyc(1);
    nvw_done = 1'b0;
    expect_state("R8", 1'b0, 1'b0, 1'b0);

    // R1: reset again mid-operation
    rst = 1'b1;
    cyc(1);
    expect_state("R1", 1'b1, 1'b0, 1'b0);

    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule